// File: doc/BRIEF.md
# Three-Port Latched Bus Crossbar

This block routes data among three 9-bit bidirectional ports, called A, B and C. Each port captures its incoming bus into its own holding register under its own load enable. A shared two-bit route code then picks which held word appears on each port's outgoing bus. Data can cross from any port to any other port. Ports A and B can also replay their own held word for a readback self-check.

Bit 8 of every word is the parity bit. A parity-flip control inverts that bit only when port C's held word is routed out on port A or port B. This lets diagnostics inject a bad parity on purpose. Bits 7..0 always pass through unchanged. The flip acts at the output, so the word held for port C is never altered.

Each pad is split into three signals: an input bus, an output bus and a drive-enable pin. The drive-enable pin follows that port's own output-enable input at once. While a port is not driving, the value on its output bus carries no meaning. The holding registers are clocked by the system clock and gated by their load enables. The block has a synchronous active-low reset.

Top module: `xbar3_latched`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three holding registers clear to zero. Nothing else is reset.
- R2: At a rising edge with a port's load enable high, that port's register takes the port's input bus. With the load enable low, the register keeps its value. Each port's load enable acts only on that port's own register.
- R3: Route code `route` (bit 1 = S1, bit 0 = S0) sets port A's outgoing word. Code 00 gives B's register, 01 gives C's register, 10 gives A's own register, and 11 gives C's register.
- R4: Port B's outgoing word is A's register for code 00, C's register for 01, B's own register for 10, and C's register for 11.
- R5: Port C's outgoing word is A's register when bit 0 of `route` is 0 and B's register when it is 1. Bit 1 of `route` and `par_flip` have no effect on it.
- R6: Readback (code 10) drives ports A and B with their own held words.
- R7: With `par_flip` high, bit 8 is inverted on A's or B's outgoing word whenever that word comes from C's register. Bits 7..0 are never inverted. No other path is affected.
- R8: `par_flip` does not change the word held for port C. Once `par_flip` is low again, the original C word reads out unchanged.
- R9: Each `*_oe` output equals its own `*_drv` input in the same cycle, independently of the other ports.
- R10: A port's register loads from its input bus even while that port's `*_drv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 9 | Port A incoming bus |
| b_in | input | 9 | Port B incoming bus |
| c_in | input | 9 | Port C incoming bus |
| a_ld | input | 1 | Load enable for A's register |
| b_ld | input | 1 | Load enable for B's register |
| c_ld | input | 1 | Load enable for C's register |
| a_drv | input | 1 | Output enable request, port A |
| b_drv | input | 1 | Output enable request, port B |
| c_drv | input | 1 | Output enable request, port C |
| route | input | 2 | Route code {S1,S0} |
| par_flip | input | 1 | Invert parity bit on C-sourced words to A/B |
| a_out | output | 9 | Port A outgoing bus |
| b_out | output | 9 | Port B outgoing bus |
| c_out | output | 9 | Port C outgoing bus |
| a_oe | output | 1 | Port A pad drive enable |
| b_oe | output | 1 | Port B pad drive enable |
| c_oe | output | 1 | Port C pad drive enable |

## Verification
A load appears on the outgoing buses at the first rising edge that sees its enable high. The bench therefore drives inputs on the falling edge and checks one falling edge later, after exactly one register stage. Route code, parity flip and drive-enable changes are combinational. The bench checks them a short settle delay after applying them, with no clock edge in between. The sweeps cover every route code with both parity-flip levels and every drive-enable combination. Expected words are derived from the bench's own copy of the three held values.

// File: rtl/xbar3_pkg.sv
// Package: shared types and the route decode for the three-port crossbar.
// Assumes ports are numbered A=0, B=1, C=2.
package xbar3_pkg;

    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_C = 2'd2
    } port_e;

    typedef enum logic [1:0] {
        RT_CROSS    = 2'b00,
        RT_FROM_C   = 2'b01,
        RT_READBACK = 2'b10,
        RT_FROM_C2  = 2'b11
    } route_e;

    // Returns the port whose held word drives output port 'dst' under route code 'rt'.
    function automatic port_e route_src(input port_e dst, input logic [1:0] rt);
        port_e s;
        case (dst)
            PORT_A: begin
                case (route_e'(rt))
                    RT_CROSS:    s = PORT_B;
                    RT_READBACK: s = PORT_A;
                    default:     s = PORT_C;
                endcase
            end
            PORT_B: begin
                case (route_e'(rt))
                    RT_CROSS:    s = PORT_A;
                    RT_READBACK: s = PORT_B;
                    default:     s = PORT_C;
                endcase
            end
            default: s = rt[0] ? PORT_B : PORT_A;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xbar3_hold_reg.sv
// Module: one port's holding register.
// Loads its input word on a rising edge while ld is high and holds it otherwise.
// Assumes a synchronous active-low reset that clears the held word.
module xbar3_hold_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R2: a load edge stores the input word.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(d));

    // R2: without a load the word stays put.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));

    // R1: leaving reset, the word is zero.
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> q == '0);

endmodule

// File: rtl/xbar3_route_mux.sv
// Module: output selector for one destination port.
// Picks a held word using the package route decode.
// Inverts the parity (top) bit when the source is C, the destination is not C and flip is high.
// Assumes lat[] is indexed by port number.
module xbar3_route_mux
    import xbar3_pkg::*;
#(
    parameter int    W   = 9,
    parameter port_e DST = PORT_A
) (
    input  logic [W-1:0] lat [3],
    input  logic [1:0]   rt,
    input  logic         par_flip,
    output logic [W-1:0] y
);

    localparam int PBIT = W - 1;

    port_e        src;
    logic [W-1:0] flip_mask;

    // Decode the source port and build the parity inversion mask.
    always_comb begin
        src       = route_src(DST, rt);
        flip_mask = '0;
        flip_mask[PBIT] = par_flip && (src == PORT_C) && (DST != PORT_C);
    end

    // Drive the selected word with the optional parity flip.
    always_comb y = lat[src] ^ flip_mask;

    // R7: the low bits always match the selected source word exactly.
    always_comb begin
        a_lowbits_r7: assert (y[PBIT-1:0] == lat[src][PBIT-1:0]);
    end

endmodule

// File: rtl/xbar3_latched.sv
// Module: three-port latched crossbar top.
// Holds one word per port and routes the held words to every port by a 2-bit code.
// Passes drive enables straight to the pad enable pins.
// Assumes split pads (in/out/oe) and a synchronous active-low reset.
module xbar3_latched
    import xbar3_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    input  logic         a_ld,
    input  logic         b_ld,
    input  logic         c_ld,
    input  logic         a_drv,
    input  logic         b_drv,
    input  logic         c_drv,
    input  logic [1:0]   route,
    input  logic         par_flip,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out,
    output logic         a_oe,
    output logic         b_oe,
    output logic         c_oe
);

    localparam int NPORT = 3;
    localparam int PBIT  = W - 1;

    logic [W-1:0] din  [NPORT];
    logic [W-1:0] held [NPORT];
    logic [W-1:0] dout [NPORT];
    logic         ld   [NPORT];

    // Gather the per-port pad signals into arrays.
    always_comb begin
        din[0] = a_in;  din[1] = b_in;  din[2] = c_in;
        ld[0]  = a_ld;  ld[1]  = b_ld;  ld[2]  = c_ld;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        xbar3_hold_reg #(.W(W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (ld[i]),
            .d    (din[i]),
            .q    (held[i])
        );
        xbar3_route_mux #(.W(W), .DST(port_e'(i))) u_mux (
            .lat     (held),
            .rt      (route),
            .par_flip(par_flip),
            .y       (dout[i])
        );
    end

    // Drive the outgoing buses and pad enables.
    always_comb begin
        a_out = dout[0];
        b_out = dout[1];
        c_out = dout[2];
        a_oe  = a_drv;
        b_oe  = b_drv;
        c_oe  = c_drv;
    end

    // R5: port C takes A or B by route bit 0 only, never flipped.
    p_cport_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_out == (route[0] ? held[1] : held[0]));

    // R7: a C-sourced word on port A carries the flip on its parity bit.
    p_aparity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        route[0] |-> a_out[PBIT] == (held[2][PBIT] ^ par_flip));

    // R6: readback returns each port's own word.
    p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        route == 2'b10 |-> (a_out == held[0] && b_out == held[1]));

    // R8: flipping parity never disturbs C's held word.
    p_cheld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_ld |=> $stable(held[2]));

endmodule

// File: tb/xbar3_latched_tb.sv
module xbar3_latched_tb_top;

    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, c_in = '0;
    logic         a_ld = 0, b_ld = 0, c_ld = 0;
    logic         a_drv = 0, b_drv = 0, c_drv = 0;
    logic [1:0]   route = 2'b00;
    logic         par_flip = 0;
    logic [W-1:0] a_out, b_out, c_out;
    logic         a_oe, b_oe, c_oe;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] ma = '0, mb = '0, mc = '0;  // bench copy of held words

    always #5 clk = ~clk;

    xbar3_latched #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .a_ld(a_ld), .b_ld(b_ld), .c_ld(c_ld),
        .a_drv(a_drv), .b_drv(b_drv), .c_drv(c_drv),
        .route(route), .par_flip(par_flip),
        .a_out(a_out), .b_out(b_out), .c_out(c_out),
        .a_oe(a_oe), .b_oe(b_oe), .c_oe(c_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_ab(input bit is_b, input logic [1:0] r, input logic pf);
        logic [W-1:0] v;
        case (r)
            2'b00: v = is_b ? ma : mb;
            2'b10: v = is_b ? mb : ma;
            default: v = mc ^ {pf, {(W-1){1'b0}}};
        endcase
        return v;
    endfunction

    // Load selected ports; drive at negedge, result seen after next posedge.
    task automatic load(input logic la, input logic lb, input logic lc,
                        input logic [W-1:0] va, input logic [W-1:0] vb, input logic [W-1:0] vc);
        @(negedge clk);
        a_in = va; b_in = vb; c_in = vc;
        a_ld = la; b_ld = lb; c_ld = lc;
        @(negedge clk);
        a_ld = 0; b_ld = 0; c_ld = 0;
        if (la) ma = va;
        if (lb) mb = vb;
        if (lc) mc = vc;
    endtask

    // Sweep all route codes and flip levels; covers R3 R4 R5 R6 R7.
    task automatic sweep();
        for (int r = 0; r < 4; r++) begin
            for (int f = 0; f < 2; f++) begin
                route = 2'(r); par_flip = 1'(f);
                #1;
                chk(r == 2 ? "R6 A readback" : (r[0] ? "R7 A from C" : "R3 A route"),
                    a_out, exp_ab(0, 2'(r), 1'(f)));
                chk(r == 2 ? "R6 B readback" : (r[0] ? "R7 B from C" : "R4 B route"),
                    b_out, exp_ab(1, 2'(r), 1'(f)));
                chk("R5 C route", c_out, r[0] ? mb : ma);
            end
        end
        par_flip = 0;
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                // R1: reset cleared everything
                route = 2'b10; #1;
                chk("R1 A reset", a_out, '0);
                chk("R1 B reset", b_out, '0);
                route = 2'b00; #1;
                chk("R1 C reset", c_out, '0);
                sweep();

                // R2 / R10: load with drives off, several patterns
                load(1, 1, 1, 9'h1A5, 9'h05A, 9'h1FF); sweep();
                load(1, 1, 1, 9'h000, 9'h1FF, 9'h0C3); sweep();
                load(1, 1, 1, 9'h155, 9'h0AA, 9'h100); sweep();
                // R10: drives off during load, value held
                route = 2'b10; #1;
                chk("R10 load while undriven", a_out, 9'h155);

                // R2: independent load enables
                load(0, 1, 0, 9'h0F0, 9'h111, 9'h0EE); sweep();
                load(0, 0, 1, 9'h033, 9'h044, 9'h1CC); sweep();
                load(1, 0, 0, 9'h1E1, 9'h0FF, 9'h000); sweep();

                // R2: hold with loads low while inputs change
                @(negedge clk);
                a_in = 9'h0; b_in = 9'h0; c_in = 9'h0;
                repeat (2) @(negedge clk);
                route = 2'b10; #1;
                chk("R2 hold A", a_out, ma);
                chk("R2 hold B", b_out, mb);
                route = 2'b01; #1;
                chk("R2 hold C", a_out, mc);

                // R8: flip then unflip, C word unchanged
                par_flip = 1;
                repeat (2) @(negedge clk);
                par_flip = 0; #1;
                chk("R8 C word kept", a_out, mc);
                chk("R8 C word kept via B", b_out, mc);

                // R9: all drive-enable combinations
                for (int d = 0; d < 8; d++) begin
                    {c_drv, b_drv, a_drv} = 3'(d);
                    #1;
                    chk("R9 oe", {6'b0, c_oe, b_oe, a_oe}, 9'(d));
                end

                // R1: mid-run reset clears registers
                @(negedge clk); rst_n = 0;
                @(negedge clk); rst_n = 1;
                ma = '0; mb = '0; mc = '0;
                sweep();
            end
            begin
                while (wd < 20000) begin
                    @(posedge clk);
                    wd++;
                end
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule